// File: doc/BRIEF.md
# Triangle-Carrier Three-Phase Gate Command Generator

This block turns three signed 16-bit phase references into gate commands for a three-phase, two-level inverter. A symmetric up/down carrier runs between zero and a programmable peak. Each reference is offset into the unsigned carrier range and compared against the carrier. The result drives an upper and a lower switch command for each half-bridge. References are sampled only at the carrier turning points, so a mid-period update cannot cut a pulse short. Each demanded level is held for a minimum number of cycles before it can change. Every switch-on edge is delayed by a programmable dead time, and switch-off edges are not delayed.

For gate drivers whose high-side supply is a bootstrap capacitor, an option forces a short pulse on every lower switch once per carrier period, starting at the carrier peak. The forced pulse does not suppress the upper switch. A saturating monitor therefore counts every clock cycle in which any leg has both commands on. The monitor can be cleared by a dedicated input. The host supplies the references, the carrier peak, the dead time and the option flags. A global enable held low parks the carrier and turns every switch off.

Top module: `tri_carrier_pwm`

## Requirements
- R1: While `en` is low, the carrier is held at 0 and every gate output is 0 from the next clock edge on. When `en` rises, the carrier starts counting up from 0.
- R2: The carrier counts up by one per clock until it reaches the peak. It then counts down by one to 0, and then counts up again. A `period` value below 2 is treated as 2.
- R3: A phase reference is captured only while disabled, or in a cycle where the carrier is turning at its peak or at 0. A reference change at any other point has no effect until the next turning point.
- R4: A phase demands its upper switch when its captured reference with bit 15 inverted (giving an unsigned value) is strictly greater than the carrier. The lower switch is demanded otherwise. Without a forced pulse, the two commands of a leg are never both high. The path from carrier to gate output is three registers deep.
- R5: Once a phase's demanded level changes, the new level is held for at least MIN_PULSE clock cycles before it can change again. Narrow demands are stretched to this width.
- R6: A gate output rises only after its demand has been high for `dead_cyc` consecutive cycles. It falls one cycle after its demand falls, with no dead time added.
- R7: With `boot_en` high, a carrier peak starts a forced pulse `boot_len` cycles long. All three lower outputs are forced high during this pulse, starting two cycles after the peak cycle, without dead time. A `boot_len` of 0 gives no pulse.
- R8: `st_count` increases by one for each clock cycle in which at least one leg shows upper and lower outputs both high. Several legs overlapping in the same cycle still add only one.
- R9: `st_count` saturates at its all-ones value.
- R10: `st_clr` high resets `st_count` to 0 at the next edge and takes priority over counting.
- R11: An asynchronous active-low `rst_n` zeros the carrier, all gate outputs and the monitor count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock (40 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low parks carrier and turns all switches off |
| ref_a | input | DATA_W | Signed reference, phase A |
| ref_b | input | DATA_W | Signed reference, phase B |
| ref_c | input | DATA_W | Signed reference, phase C |
| period | input | DATA_W | Carrier peak count |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| boot_en | input | 1 | Enables the forced lower-switch pulse |
| boot_len | input | BOOT_W | Forced pulse width in cycles |
| st_clr | input | 1 | Clears the overlap counter |
| up_gate | output | NPH | Upper switch commands, bit 0 = phase A |
| lo_gate | output | NPH | Lower switch commands, bit 0 = phase A |
| st_count | output | ST_W | Saturating count of overlap cycles |

## Verification
The bench builds the block with MIN_PULSE = 4 and ST_W = 4, and drives a carrier peak of 40 at run time. With these values, stretched pulses, complete carrier periods and counter saturation (15 cycles, reached within three forced pulses) all fit in a few hundred cycles. Because the bench keeps the default DATA_W of 16, references close to the ends of a 0..40 carrier are used to produce one-cycle demands for the stretching check. A reference above the peak holds an upper switch on through the forced pulse, which creates real overlap for the monitor to count. A peak value of 1 exercises the clamp to 2.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } carrier_dir_e;

    localparam int unsigned MIN_PEAK = 2;
endpackage

// File: rtl/tpg_carrier.sv
module tpg_carrier
    import tpg_pkg::*;
#(
    parameter int CW     = 16,
    parameter int BOOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CW-1:0]     period,
    input  logic              boot_en,
    input  logic [BOOT_W-1:0] boot_len,
    output logic [CW-1:0]     cnt_o,
    output logic              at_peak_o,
    output logic              at_valley_o,
    output logic              force_lo_o
);
    localparam logic [CW-1:0] PEAK_FLOOR = CW'(MIN_PEAK);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        carrier_dir_e      dir;
        logic [BOOT_W-1:0] boot;
    } car_st_t;

    car_st_t st_d, st_q;
    logic [CW-1:0] peak_eff;
    logic          at_peak, at_valley;

    always_comb begin
        peak_eff  = (period < PEAK_FLOOR) ? PEAK_FLOOR : period;
        at_peak   = en && (st_q.dir == DIR_UP) && (st_q.cnt >= peak_eff);
        at_valley = en && (st_q.dir == DIR_DOWN) && (st_q.cnt == '0);
        st_d      = st_q;
        if (!en) begin
            st_d.cnt  = '0;
            st_d.dir  = DIR_UP;
            st_d.boot = '0;
        end else begin
            if (st_q.dir == DIR_UP) begin
                if (at_peak) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    st_d.dir = DIR_DOWN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (at_valley) begin
                    st_d.cnt = CW'(1);
                    st_d.dir = DIR_UP;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            if (boot_en && at_peak) begin
                st_d.boot = boot_len;
            end else if (st_q.boot != '0) begin
                st_d.boot = st_q.boot - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP, boot: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign at_peak_o   = at_peak;
    assign at_valley_o = at_valley;
    assign force_lo_o  = (st_q.boot != '0);

    // R2: while running, the carrier only ever moves by one step
    assert_carrier_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && st_q.cnt != $past(st_q.cnt)) |->
        (st_q.cnt == $past(st_q.cnt) + 1'b1 || st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R1: a disabled cycle leaves the carrier at zero
    assert_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0));
endmodule

// File: rtl/tpg_leg.sv
module tpg_leg #(
    parameter int DW        = 16,
    parameter int DT_W      = 8,
    parameter int MIN_PULSE = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] ref_in,
    input  logic [DW-1:0]        cnt,
    input  logic                 latch,
    input  logic [DT_W-1:0]      dead,
    input  logic                 force_lo,
    output logic                 up_o,
    output logic                 lo_o
);
    localparam int HW = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE);
    localparam logic [HW-1:0]   HOLD_LOAD = HW'(MIN_PULSE - 1);
    localparam logic [DT_W-1:0] RUN_MAX   = {DT_W{1'b1}};
    localparam logic [DW-1:0]   SIGN_FLIP = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [DW-1:0]   ref_lat;
        logic            dem;
        logic            flt;
        logic [HW-1:0]   hold;
        logic [DT_W-1:0] run_up;
        logic [DT_W-1:0] run_lo;
        logic            up;
        logic            lo;
    } leg_st_t;

    leg_st_t st_d, st_q;
    logic [DW-1:0] ref_u;
    logic          raw_up, raw_lo;

    always_comb begin
        st_d  = st_q;
        ref_u = st_q.ref_lat ^ SIGN_FLIP;
        if (latch) begin
            st_d.ref_lat = ref_in;
        end
        st_d.dem = en && (ref_u > cnt);

        if (!en) begin
            st_d.flt  = 1'b0;
            st_d.hold = '0;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end else if (st_q.dem != st_q.flt) begin
            st_d.flt  = st_q.dem;
            st_d.hold = HOLD_LOAD;
        end

        raw_up = en && st_q.flt;
        raw_lo = en && !st_q.flt;
        st_d.run_up = !raw_up ? '0 :
                      (st_q.run_up == RUN_MAX) ? RUN_MAX : st_q.run_up + 1'b1;
        st_d.run_lo = !raw_lo ? '0 :
                      (st_q.run_lo == RUN_MAX) ? RUN_MAX : st_q.run_lo + 1'b1;
        st_d.up = raw_up && (st_q.run_up >= dead);
        st_d.lo = en && ((raw_lo && (st_q.run_lo >= dead)) || force_lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_o = st_q.up;
    assign lo_o = st_q.lo;

    // R4: both commands high only as the result of a forced lower pulse
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.lo) |-> ($past(force_lo) && $past(en)));

    // R6: an upper switch-on edge follows a full dead-time run of demand
    assert_dead_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.up) |-> ($past(st_q.run_up) >= $past(dead)));

    // R5: a freshly changed level cannot flip back on the next edge
    assert_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.hold == HOLD_LOAD && HOLD_LOAD != '0) |=> (!en || st_q.flt == $past(st_q.flt)));
endmodule

// File: rtl/tpg_overlap_mon.sv
module tpg_overlap_mon #(
    parameter int NL   = 3,
    parameter int ST_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NL-1:0]   up,
    input  logic [NL-1:0]   lo,
    input  logic            clr,
    output logic [ST_W-1:0] count_o
);
    localparam logic [ST_W-1:0] CNT_MAX = {ST_W{1'b1}};

    typedef struct packed {
        logic [ST_W-1:0] cnt;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = |(up & lo);
        if (clr) begin
            st_d.cnt = '0;
        end else if (hit && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr) |=> (st_q.cnt == CNT_MAX));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

    // R8: the count never moves by more than one per cycle
    assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && st_q.cnt != $past(st_q.cnt)) |-> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/tri_carrier_pwm.sv
module tri_carrier_pwm #(
    parameter int DATA_W    = 16,
    parameter int DT_W      = 8,
    parameter int BOOT_W    = 8,
    parameter int ST_W      = 16,
    parameter int MIN_PULSE = 20,
    parameter int NPH       = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] ref_a,
    input  logic signed [DATA_W-1:0] ref_b,
    input  logic signed [DATA_W-1:0] ref_c,
    input  logic [DATA_W-1:0]        period,
    input  logic [DT_W-1:0]          dead_cyc,
    input  logic                     boot_en,
    input  logic [BOOT_W-1:0]        boot_len,
    input  logic                     st_clr,
    output logic [NPH-1:0]           up_gate,
    output logic [NPH-1:0]           lo_gate,
    output logic [ST_W-1:0]          st_count
);
    logic [DATA_W-1:0]        cnt;
    logic                     at_peak, at_valley, force_lo, latch;
    logic signed [DATA_W-1:0] refs [NPH];

    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            refs[i] = (i % 3 == 0) ? ref_a : (i % 3 == 1) ? ref_b : ref_c;
        end
        latch = !en || at_peak || at_valley;
    end

    tpg_carrier #(.CW(DATA_W), .BOOT_W(BOOT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period),
        .boot_en(boot_en), .boot_len(boot_len),
        .cnt_o(cnt), .at_peak_o(at_peak), .at_valley_o(at_valley),
        .force_lo_o(force_lo)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        tpg_leg #(.DW(DATA_W), .DT_W(DT_W), .MIN_PULSE(MIN_PULSE)) u_leg (
            .clk(clk), .rst_n(rst_n), .en(en), .ref_in(refs[g]),
            .cnt(cnt), .latch(latch), .dead(dead_cyc), .force_lo(force_lo),
            .up_o(up_gate[g]), .lo_o(lo_gate[g])
        );
    end

    tpg_overlap_mon #(.NL(NPH), .ST_W(ST_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .up(up_gate), .lo(lo_gate),
        .clr(st_clr), .count_o(st_count)
    );

    assert_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (up_gate == '0 && lo_gate == '0));

    assert_boot_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && force_lo) |=> (lo_gate == '1));
endmodule

// File: tb/tri_carrier_pwm_tb.sv
module tri_carrier_pwm_tb;
    localparam int MINP = 4;
    localparam int STW  = 4;
    localparam int DTMAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] ra = '0, rb = '0, rc = '0;
    logic [15:0] period = 16'd40;
    logic [7:0]  dead = '0;
    logic        boot_en = 1'b0;
    logic [7:0]  boot_len = '0;
    logic        st_clr = 1'b0;
    logic [2:0]  up_gate, lo_gate;
    logic [STW-1:0] st_count;

    int checks = 0, fails = 0;
    string cur_req = "R11";
    bit done = 0;

    always #10 clk = ~clk;

    tri_carrier_pwm #(.ST_W(STW), .MIN_PULSE(MINP)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .ref_a(ra), .ref_b(rb), .ref_c(rc), .period(period),
        .dead_cyc(dead), .boot_en(boot_en), .boot_len(boot_len),
        .st_clr(st_clr), .up_gate(up_gate), .lo_gate(lo_gate),
        .st_count(st_count)
    );

    // behavioural reference model
    int m_cnt, m_dirup, m_b, m_st;
    int m_rl[3], m_dem[3], m_f[3], m_h[3], m_ru[3], m_rlo[3], m_uo[3], m_lo[3];

    function automatic logic [15:0] mk(input int u);
        return 16'(u) ^ 16'h8000;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int pe, ncnt, ndir, nb, nst, anyov;
        bit pk, vl;
        int rin[3];
        int nrl[3], ndem[3], nf[3], nh[3], nru[3], nrlo[3], nuo[3], nlo[3];
        if (!rst_n) begin
            m_cnt = 0; m_dirup = 1; m_b = 0; m_st = 0;
            for (int i = 0; i < 3; i++) begin
                m_rl[i] = 0; m_dem[i] = 0; m_f[i] = 0; m_h[i] = 0;
                m_ru[i] = 0; m_rlo[i] = 0; m_uo[i] = 0; m_lo[i] = 0;
            end
        end else begin
            rin[0] = int'(ra); rin[1] = int'(rb); rin[2] = int'(rc);
            pe = (period < 2) ? 2 : int'(period);
            pk = en && m_dirup == 1 && m_cnt >= pe;
            vl = en && m_dirup == 0 && m_cnt == 0;
            if (!en) begin ncnt = 0; ndir = 1; end
            else if (m_dirup == 1) begin
                if (pk) begin ncnt = m_cnt - 1; ndir = 0; end
                else begin ncnt = m_cnt + 1; ndir = 1; end
            end else begin
                if (vl) begin ncnt = 1; ndir = 1; end
                else begin ncnt = m_cnt - 1; ndir = 0; end
            end
            if (!en) nb = 0;
            else if (boot_en && pk) nb = int'(boot_len);
            else nb = (m_b > 0) ? m_b - 1 : 0;
            anyov = 0;
            for (int i = 0; i < 3; i++) begin
                if (m_uo[i] != 0 && m_lo[i] != 0) anyov = 1;
                nrl[i] = (!en || pk || vl) ? rin[i] : m_rl[i];
                ndem[i] = (en && ((m_rl[i] ^ 32'h8000) > m_cnt)) ? 1 : 0;
                nf[i] = m_f[i]; nh[i] = m_h[i];
                if (!en) begin nf[i] = 0; nh[i] = 0; end
                else if (m_h[i] > 0) nh[i] = m_h[i] - 1;
                else if (m_dem[i] != m_f[i]) begin nf[i] = m_dem[i]; nh[i] = MINP - 1; end
                nru[i]  = (en && m_f[i] == 1) ? ((m_ru[i] < DTMAX) ? m_ru[i] + 1 : DTMAX) : 0;
                nrlo[i] = (en && m_f[i] == 0) ? ((m_rlo[i] < DTMAX) ? m_rlo[i] + 1 : DTMAX) : 0;
                nuo[i]  = (en && m_f[i] == 1 && m_ru[i] >= int'(dead)) ? 1 : 0;
                nlo[i]  = (en && ((m_f[i] == 0 && m_rlo[i] >= int'(dead)) || m_b > 0)) ? 1 : 0;
            end
            if (st_clr) nst = 0;
            else if (anyov != 0 && m_st < (1 << STW) - 1) nst = m_st + 1;
            else nst = m_st;
            m_cnt = ncnt; m_dirup = ndir; m_b = nb; m_st = nst;
            for (int i = 0; i < 3; i++) begin
                m_rl[i] = nrl[i]; m_dem[i] = ndem[i]; m_f[i] = nf[i]; m_h[i] = nh[i];
                m_ru[i] = nru[i]; m_rlo[i] = nrlo[i]; m_uo[i] = nuo[i]; m_lo[i] = nlo[i];
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            int eu, el;
            eu = m_uo[0] + 2 * m_uo[1] + 4 * m_uo[2];
            el = m_lo[0] + 2 * m_lo[1] + 4 * m_lo[2];
            chk(cur_req, "up_gate", int'(up_gate), eu);
            chk(cur_req, "lo_gate", int'(lo_gate), el);
            chk(cur_req, "st_count", int'(st_count), m_st);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cur_req = "R11";
        step(3);
        chk("R11", "reset up", int'(up_gate), 0);
        chk("R11", "reset lo", int'(lo_gate), 0);
        rst_n = 1'b1;
        step(2);
        // R2 / R4: mid-range references, no dead time
        cur_req = "R4";
        ra = mk(20); rb = mk(10); rc = mk(30);
        en = 1'b1;
        step(250);
        // R3: references changed away from turning points
        cur_req = "R3";
        step(7);
        ra = mk(35); rb = mk(5);
        step(13);
        rc = mk(12);
        step(200);
        // R5: one-cycle demands must be stretched
        cur_req = "R5";
        ra = mk(1); rb = mk(40); rc = mk(39);
        step(300);
        // R6: dead time on rising edges
        cur_req = "R6";
        ra = mk(20); rb = mk(8); rc = mk(33);
        dead = 8'd3;
        step(250);
        dead = 8'd7;
        step(250);
        // R7 / R8 / R9: forced lower pulses against a held upper switch
        cur_req = "R7";
        dead = 8'd2;
        ra = mk(41);
        boot_en = 1'b1; boot_len = 8'd5;
        step(200);
        cur_req = "R9";
        step(200);
        chk("R9", "saturated count", int'(st_count), 15);
        // R10: clear wins over counting
        cur_req = "R10";
        st_clr = 1'b1;
        step(1);
        st_clr = 1'b0;
        chk("R10", "cleared count", int'(st_count), 0);
        cur_req = "R8";
        boot_len = 8'd0;
        step(200);
        boot_len = 8'd3;
        step(200);
        // R1: disable parks everything
        cur_req = "R1";
        en = 1'b0;
        step(2);
        chk("R1", "off up", int'(up_gate), 0);
        chk("R1", "off lo", int'(lo_gate), 0);
        step(20);
        boot_en = 1'b0;
        en = 1'b1;
        // R2: peak below the floor is clamped
        cur_req = "R2";
        period = 16'd1;
        ra = mk(2); rb = mk(1); rc = mk(0);
        step(60);
        period = 16'd40;
        ra = mk(25); rb = mk(15); rc = mk(5);
        step(150);
        // R11: asynchronous reset mid-run
        cur_req = "R11";
        #3 rst_n = 1'b0;
        step(2);
        chk("R11", "reset up mid-run", int'(up_gate), 0);
        chk("R11", "reset lo mid-run", int'(lo_gate), 0);
        chk("R11", "reset count", int'(st_count), 0);
        rst_n = 1'b1;
        step(150);
        finish_run();
    end
endmodule